// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Register

This block is the arithmetic and logic datapath of a small 8-bit RISC core. Each cycle in which `go` is high, it combines the operand bytes `opa` and `opb` (and, for some operations, the 6-bit immediate `imm`) under the operation code `op`. The byte result is returned combinationally in the same cycle. A registered 8-bit status word holds the condition flags. Each operation rewrites only its own subset of those flags. The carry consumed by the carry-chained operations is the status word's own C bit.

Two word operations add or subtract a 6-bit constant to or from a 16-bit register pair. `opa` carries the low byte and `opb` the high byte. The low byte of the result appears in the cycle `go` is high, and the high byte appears in the following cycle, during which `busy` is high. Two further codes set or clear a single status bit. The register file and instruction decode outside the block use `res_we` and `res_hi` to decide where the result goes.

Top module: `alu8_sreg`

## Requirements
- R1: Codes 0 (add), 1 (add with C), 2 (subtract) and 3 (subtract with C) return the 8-bit result with `res_we`=1 and update Z, C, N, V, S and H. Status bits are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. H is the carry out of bit 3 (or the borrow into bit 4), V is two's-complement overflow, C is the carry or borrow out of bit 7, and S = N xor V.
- R2: Codes 4 (compare) and 5 (compare with C) update flags exactly as codes 2 and 3 do, but hold `res_we` at 0.
- R3: Codes 3 and 5 clear Z when their result is nonzero and otherwise leave Z as it was, so a chained multi-byte compare keeps Z only when every byte matched.
- R4: Codes 6 (and), 7 (or) and 8 (xor) write the result, clear V, set Z, N and S from the result, and keep C and H.
- R5: Codes 11 (increment), 12 (decrement) and 13 (clear) write the result and keep C and H. V is set only when increment takes 0x7F to 0x80 or decrement takes 0x80 to 0x7F. Clear gives 0x00 with Z=1 and N=V=S=0.
- R6: Code 9 returns 255 minus `opa`, sets C, clears V and keeps H. Code 10 returns 256 minus `opa` (mod 256), sets C unless the result is zero, sets V only for 0x80, and sets H from the borrow of 0 minus `opa`.
- R7: Codes 14 (pair add) and 15 (pair subtract) form {opb,opa} ± imm. The low byte comes out in the `go` cycle with `res_hi`=0. The high byte comes out one cycle later with `busy`=1 and `res_hi`=1. Z, C, N, V and S take their 16-bit values at the edge that ends the second cycle, and H is kept.
- R8: A `go` that arrives while `busy` is high is ignored.
- R9: Code 16 sets and code 17 clears the status bit at index `imm[2:0]`, with `res_we`=0 and no other bit changed.
- R10: Codes 18 to 31 leave the status word unchanged and hold `res_we` at 0.
- R11: Reset clears the status word and `busy`, and with `go` low `res_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Execute `op` in this cycle |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand; low byte of a pair |
| opb | input | 8 | Second operand; high byte of a pair |
| imm | input | 6 | Pair constant, or status bit index in bits 2:0 |
| res | output | 8 | Result byte |
| res_we | output | 1 | Result is to be written back |
| res_hi | output | 1 | Result is the high byte of a pair |
| busy | output | 1 | Second cycle of a pair operation |
| sreg | output | 8 | Status word |

## Verification
A byte result is due combinationally in the cycle its `go` is high, and the matching status word is due after the next rising edge. For a pair operation, the low byte is due in the `go` cycle and the high byte one cycle later. Its flags are due only after the second rising edge, and the status word must still hold its old value between those two edges. The bench applies every stimulus at a falling edge. It samples `res`, `res_we` and `res_hi` 5 ns later, before the rising edge, and samples `sreg` at the following falling edge, where its behavioural model has advanced by exactly one operation.

// File: rtl/alu8_sreg.sv
module alu8_sreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [4:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [5:0] imm,
  output logic [7:0] res,
  output logic       res_we,
  output logic       res_hi,
  output logic       busy,
  output logic [7:0] sreg
);
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBC  = 5'd3;
  localparam logic [4:0] OP_CP   = 5'd4;
  localparam logic [4:0] OP_CPC  = 5'd5;
  localparam logic [4:0] OP_AND  = 5'd6;
  localparam logic [4:0] OP_OR   = 5'd7;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_COM  = 5'd9;
  localparam logic [4:0] OP_NEG  = 5'd10;
  localparam logic [4:0] OP_INC  = 5'd11;
  localparam logic [4:0] OP_DEC  = 5'd12;
  localparam logic [4:0] OP_CLR  = 5'd13;
  localparam logic [4:0] OP_WADD = 5'd14;
  localparam logic [4:0] OP_WSUB = 5'd15;
  localparam logic [4:0] OP_BSET = 5'd16;
  localparam logic [4:0] OP_BCLR = 5'd17;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic [7:0] st, nst, ax, ay, ar, lr, whi;
  logic [8:0] a9;
  logic       ac, as, aco, ah, av;
  logic       wbusy, wsub, wcar, wloz;

  wire start   = go && !wbusy;
  wire is_word = (op == OP_WADD) || (op == OP_WSUB);

  assign busy = wbusy;
  assign sreg = st;

  always_comb begin
    ax = opa; ay = opb; ac = 1'b0; as = 1'b0;
    if (wbusy) begin
      ax = whi; ay = 8'h00; ac = wcar; as = wsub;
    end else begin
      case (op)
        OP_ADC:         ac = st[FC];
        OP_SUB, OP_CP:  as = 1'b1;
        OP_SBC, OP_CPC: begin as = 1'b1; ac = st[FC]; end
        OP_NEG:         begin ax = 8'h00; ay = opa; as = 1'b1; end
        OP_INC:         ay = 8'h01;
        OP_DEC:         begin ay = 8'h01; as = 1'b1; end
        OP_WADD:        ay = {2'b00, imm};
        OP_WSUB:        begin ay = {2'b00, imm}; as = 1'b1; end
        default: ;
      endcase
    end
  end

  assign a9  = as ? ({1'b0, ax} - {1'b0, ay} - {8'h00, ac})
                  : ({1'b0, ax} + {1'b0, ay} + {8'h00, ac});
  assign ar  = a9[7:0];
  assign aco = a9[8];
  assign ah  = as ? ((~ax[3] & ay[3]) | (ay[3] & ar[3]) | (ar[3] & ~ax[3]))
                  : ((ax[3] & ay[3]) | (ay[3] & ~ar[3]) | (~ar[3] & ax[3]));
  assign av  = as ? ((ax[7] & ~ay[7] & ~ar[7]) | (~ax[7] & ay[7] & ar[7]))
                  : ((ax[7] & ay[7] & ~ar[7]) | (~ax[7] & ~ay[7] & ar[7]));

  always_comb begin
    case (op)
      OP_AND:  lr = opa & opb;
      OP_OR:   lr = opa | opb;
      OP_XOR:  lr = opa ^ opb;
      OP_COM:  lr = ~opa;
      default: lr = 8'h00;
    endcase
  end

  always_comb begin
    res = ar; res_we = 1'b0; res_hi = 1'b0; nst = st;
    if (wbusy) begin
      res_we  = 1'b1;
      res_hi  = 1'b1;
      nst[FC] = aco;
      nst[FZ] = wloz & (ar == 8'h00);
      nst[FN] = ar[7];
      nst[FV] = av;
      nst[FS] = ar[7] ^ av;
    end else if (go) begin
      case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
          res_we  = (op != OP_CP) && (op != OP_CPC);
          nst[FC] = aco;
          nst[FH] = ah;
          nst[FV] = av;
          nst[FN] = ar[7];
          nst[FS] = ar[7] ^ av;
          nst[FZ] = (op == OP_SBC || op == OP_CPC) ? (st[FZ] & (ar == 8'h00))
                                                    : (ar == 8'h00);
        end
        OP_AND, OP_OR, OP_XOR, OP_COM, OP_CLR: begin
          res     = lr;
          res_we  = 1'b1;
          nst[FV] = 1'b0;
          nst[FN] = lr[7];
          nst[FS] = lr[7];
          nst[FZ] = (lr == 8'h00);
          if (op == OP_COM) nst[FC] = 1'b1;
        end
        OP_INC, OP_DEC: begin
          res_we  = 1'b1;
          nst[FV] = av;
          nst[FN] = ar[7];
          nst[FS] = ar[7] ^ av;
          nst[FZ] = (ar == 8'h00);
        end
        OP_WADD, OP_WSUB: res_we = 1'b1;
        OP_BSET: nst[imm[2:0]] = 1'b1;
        OP_BCLR: nst[imm[2:0]] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 8'h00; wbusy <= 1'b0; wsub <= 1'b0; wcar <= 1'b0; wloz <= 1'b0; whi <= 8'h00;
    end else begin
      st    <= nst;
      wbusy <= start && is_word;
      if (start && is_word) begin
        whi  <= opb;
        wsub <= (op == OP_WSUB);
        wcar <= aco;
        wloz <= (ar == 8'h00);
      end
    end
  end

  assert_cmp_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_CP || op == OP_CPC)) |-> !res_we);
  assert_cpc_zsticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CPC && !sreg[FZ]) |=> !sreg[FZ]);
  assert_logic_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
    (sreg[FC] == $past(sreg[FC]) && sreg[FH] == $past(sreg[FH]) && !sreg[FV]));
  assert_com_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_COM) |=> sreg[FC]);
  assert_pair_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_word) |=> (busy && res_hi && res_we));
  assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_undef_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > OP_BCLR) |=> $stable(sreg));
endmodule

// File: tb/test_alu8_sreg.sv
module test_alu8_sreg;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, go, res_we, res_hi, busy;
  logic [4:0] op;
  logic [7:0] opa, opb, res, sreg;
  logic [5:0] imm;

  alu8_sreg i_alu8_sreg (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .opa(opa), .opb(opb), .imm(imm),
    .res(res), .res_we(res_we), .res_hi(res_hi), .busy(busy), .sreg(sreg));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] m_st;
  logic [7:0] cv [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};

  task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic int sg(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string tg(int o);
    if (o <= 3) return "R1";
    if (o <= 5) return "R2";
    if (o <= 8) return "R4";
    if (o <= 10) return "R6";
    if (o <= 13) return "R5";
    if (o <= 15) return "R7";
    if (o <= 17) return "R9";
    return "R10";
  endfunction

  task automatic model_byte(input int o, input int a, input int b, input int k,
                            output int r, output bit we, output logic [7:0] ns);
    bit c, z, n, v, h, upd;
    int f, cc, s;
    ns = m_st; c = m_st[0]; z = m_st[1]; n = m_st[2]; v = m_st[3]; h = m_st[5];
    r = 0; we = 0; upd = 0;
    if (o <= 5 || o == 10) begin
      cc = (o == 1 || o == 3 || o == 5) ? int'(m_st[0]) : 0;
      if (o == 10) begin f = -a; h = (a % 16) != 0; s = -sg(a); end
      else if (o <= 1) begin f = a + b + cc; h = (a % 16 + b % 16 + cc) > 15; s = sg(a) + sg(b) + cc; end
      else begin f = a - b - cc; h = (a % 16 - b % 16 - cc) < 0; s = sg(a) - sg(b) - cc; end
      r = f & 255;
      c = (o <= 1) ? (f > 255) : (f < 0);
      v = (s > 127) || (s < -128);
      z = (o == 3 || o == 5) ? (r == 0 && m_st[1]) : (r == 0);
      we = !(o == 4 || o == 5); upd = 1;
    end else if (o == 6 || o == 7 || o == 8 || o == 9 || o == 13) begin
      case (o)
        6: r = a & b;
        7: r = a | b;
        8: r = a ^ b;
        9: begin r = 255 - a; c = 1; end
        default: r = 0;
      endcase
      v = 0; z = (r == 0); we = 1; upd = 1;
    end else if (o == 11 || o == 12) begin
      r = (o == 11) ? (a + 1) & 255 : (a - 1) & 255;
      v = (o == 11) ? (a == 127) : (a == 128);
      z = (r == 0); we = 1; upd = 1;
    end else if (o == 16) ns[k % 8] = 1'b1;
    else if (o == 17) ns[k % 8] = 1'b0;
    if (upd) begin
      n = r > 127;
      ns[0] = c; ns[1] = z; ns[2] = n; ns[3] = v; ns[4] = n ^ v; ns[5] = h;
    end
  endtask

  task automatic model_word(input int o, input int lo, input int hi, input int k,
                            output int rlo, output int rhi, output logic [7:0] ns);
    int w, sw, f, s, r16;
    bit v;
    w = hi * 256 + lo; sw = (w > 32767) ? w - 65536 : w;
    ns = m_st;
    if (o == 14) begin f = w + k; ns[0] = f > 65535; s = sw + k; v = s > 32767; end
    else begin f = w - k; ns[0] = f < 0; s = sw - k; v = s < -32768; end
    r16 = f & 65535;
    rlo = r16 % 256; rhi = r16 / 256;
    ns[1] = (r16 == 0); ns[2] = r16 > 32767; ns[3] = v; ns[4] = (r16 > 32767) ^ v;
  endtask

  task automatic run_byte(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [5:0] k);
    int er; bit ewe; logic [7:0] ns;
    string t = tg(o);
    model_byte(int'(o), int'(a), int'(b), int'(k), er, ewe, ns);
    @(negedge clk);
    go = 1; op = o; opa = a; opb = b; imm = k;
    #5;
    chk({t, " we"}, 16'(res_we), 16'(ewe));
    if (ewe) chk({t, " res"}, 16'(res), 16'(er));
    @(negedge clk);
    go = 0;
    chk({t, " sreg"}, 16'(sreg), 16'(ns));
    m_st = ns;
  endtask

  task automatic run_word(input logic [4:0] o, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [5:0] k, input bit intrude);
    int rl, rh; logic [7:0] ns;
    model_word(int'(o), int'(lo), int'(hi), int'(k), rl, rh, ns);
    @(negedge clk);
    go = 1; op = o; opa = lo; opb = hi; imm = k;
    #5;
    chk("R7 low byte", 16'(res), 16'(rl));
    chk("R7 low select", {14'h0, res_we, res_hi}, 16'h0002);
    @(negedge clk);
    if (intrude) begin go = 1; op = 5'd13; opa = 8'h5A; opb = 8'hA5; end
    else go = 0;
    #5;
    chk("R7 high byte", 16'(res), 16'(rh));
    chk("R7 high select", {13'h0, busy, res_we, res_hi}, 16'h0007);
    chk("R7 flags held", 16'(sreg), 16'(m_st));
    @(negedge clk);
    go = 0;
    chk(intrude ? "R8 ignored go" : "R7 flags", 16'(sreg), 16'(ns));
    chk(intrude ? "R8 busy" : "R7 busy", 16'(busy), 16'h0000);
    m_st = ns;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; go = 0; op = 0; opa = 0; opb = 0; imm = 0; m_st = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 sreg", 16'(sreg), 16'h0000);
    chk("R11 busy", 16'(busy), 16'h0000);
    chk("R11 we", 16'(res_we), 16'h0000);

    for (int o = 0; o < 14; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          run_byte(5'(o), cv[i], cv[j], 6'd0);
          run_byte(5'd1, cv[j], cv[i], 6'd0);
        end

    // R3 chained compare
    run_byte(5'd4, 8'h12, 8'h12, 0);
    chk("R3 z set", 16'(sreg[1]), 16'h0001);
    run_byte(5'd5, 8'h34, 8'h34, 0);
    chk("R3 z kept", 16'(sreg[1]), 16'h0001);
    run_byte(5'd5, 8'h35, 8'h34, 0);
    chk("R3 z cleared", 16'(sreg[1]), 16'h0000);
    run_byte(5'd5, 8'h00, 8'h00, 0);
    chk("R3 z stays clear", 16'(sreg[1]), 16'h0000);

    for (int i = 0; i < 500; i++)
      run_byte(5'($urandom_range(0, 13)), 8'($urandom), 8'($urandom), 6'd0);

    for (int b = 0; b < 8; b++) run_byte(5'd16, 8'h00, 8'h00, 6'(b));
    for (int b = 0; b < 8; b++) run_byte(5'd17, 8'hFF, 8'hFF, 6'(b + 8));
    run_byte(5'd16, 8'h00, 8'h00, 6'd5);
    for (int o = 18; o < 32; o++) run_byte(5'(o), 8'($urandom), 8'($urandom), 6'($urandom));

    run_word(5'd14, 8'hFF, 8'hFF, 6'd1, 0);
    run_word(5'd15, 8'h00, 8'h00, 6'd1, 0);
    run_word(5'd14, 8'hFF, 8'h7F, 6'd1, 0);
    run_word(5'd15, 8'h00, 8'h80, 6'd1, 0);
    run_word(5'd14, 8'hC1, 8'h12, 6'd63, 1);
    run_word(5'd15, 8'h3F, 8'h00, 6'd63, 1);
    run_word(5'd14, 8'h00, 8'h00, 6'd0, 0);
    for (int i = 0; i < 60; i++)
      run_word(5'($urandom_range(14, 15)), 8'($urandom), 8'($urandom), 6'($urandom), bit'($urandom));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule